// File: doc/BRIEF.md
# Priority-Interleaving Link Packet Transmitter

This block drives one direction of a point-to-point chip link with an 8-bit byte lane and a single control flag. Two sources feed it. A transfer queue presents a descriptor: a header of 8 or 12 bytes and a payload length. The payload is then fetched as 32-bit words from a separate word stream. A priority port presents short command packets of 4 or 8 bytes. Each clock the block puts out one byte, and the flag tells the receiver whether that byte belongs to a control packet (header, command or filler) or to payload.

A pending command does not wait for a long transfer to end. At each 4-byte payload boundary the priority port wins. The command goes out whole, and the paused payload then resumes where it stopped. Headers and commands are atomic units, and nothing is inserted into them. When there is nothing to send, or the payload source has no word ready, the lane carries filler bytes: zero data with the flag high, which the receiver discards as no-operation.

Top module: `prio_link_tx`

## Requirements
- R1: After a synchronous reset the lane shows a filler byte (data 0x00, flag 1), `len_err` is low, `xfer_ready` and `cmd_ready` are high and `pay_ready` is low.
- R2: With no command, no descriptor and no active transfer, every lane cycle is a filler byte.
- R3: An accepted descriptor sends its header first, least significant byte of `xfer_hdr` first, with the flag high. It is 12 bytes when `xfer_hdr_long` is 1 and 8 bytes (the low eight) when it is 0.
- R4: Payload bytes follow the header with the flag low. Each word goes out byte 0 (`pay_data[7:0]`) first, and exactly `xfer_len` payload bytes are sent.
- R5: A command is sent least significant byte of `cmd_data` first, with the flag high. It is 8 bytes when `cmd_long` is 1 and 4 bytes (the low four) when it is 0.
- R6: A command that is pending when a payload word boundary is reached goes out before the next payload word. The rest of the payload then follows in order.
- R7: A header is never split. A command that arrives during a header goes out right after the header's last byte.
- R8: A command is never split. A second command waits until the first one's last byte has been sent, then follows at once.
- R9: A descriptor whose `xfer_len` is not a multiple of 4 in the range 4..64 is consumed by its handshake. `len_err` is high for the following cycle only, and nothing but filler is sent for it.
- R10: If no payload word is offered at a word boundary, one filler byte is sent per cycle until a word arrives. The payload then continues intact.
- R11: Reset during a transfer drops it. Afterwards no more payload words are requested, and a new descriptor is accepted.
- R12: While a transfer still has payload left, `xfer_ready` stays low. A pending command holds both `xfer_ready` and `pay_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Priority command offered |
| cmd_ready | output | 1 | Command taken at this edge if valid |
| cmd_long | input | 1 | 1 = 8-byte command, 0 = 4-byte |
| cmd_data | input | 64 | Command bytes, byte 0 in bits 7:0 |
| xfer_valid | input | 1 | Transfer descriptor offered |
| xfer_ready | output | 1 | Descriptor taken at this edge if valid |
| xfer_hdr_long | input | 1 | 1 = 12-byte header, 0 = 8-byte |
| xfer_len | input | 7 | Payload length in bytes |
| xfer_hdr | input | 96 | Header bytes, byte 0 in bits 7:0 |
| pay_valid | input | 1 | Payload word offered |
| pay_ready | output | 1 | Payload word taken at this edge if valid |
| pay_data | input | 32 | Payload word, first byte in bits 7:0 |
| lane_data | output | 8 | Byte on the link lane |
| lane_ctl | output | 1 | 1 = control/filler byte, 0 = payload byte |
| len_err | output | 1 | One-cycle flag for a rejected descriptor |

## Verification
The bench puts commands at different points of a transfer: before the first payload word while the header is still going out, in the middle of the payload, after the last word, and back to back. A design that pre-empted too eagerly would split a header or a command. One that pre-empted too late would leave the command behind the whole payload. Either way the recorded byte order would differ. Payload starvation is tested too, so a design that sent stale bytes or skipped a word would be caught. So would one that marked the gap with the wrong flag. Bad lengths at 0, 6 and 68 must raise the flag for one cycle only, with no header on the lane. A reset in the middle of a transfer must leave no pending word requests behind.

// File: rtl/plt_pkg.sv
package plt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEG_FILL = 2'd0,
    SEG_CMD  = 2'd1,
    SEG_HDR  = 2'd2,
    SEG_PAY  = 2'd3
  } seg_kind_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/plt_pick.sv
// Chooses which segment is loaded at the next segment boundary.
module plt_pick
  import plt_pkg::*;
(
  input  logic      at_edge,
  input  logic      cmd_valid,
  input  logic      xfer_valid,
  input  logic      len_ok,
  input  logic      busy,
  input  logic      pay_valid,
  output logic      cmd_ready,
  output logic      xfer_ready,
  output logic      pay_ready,
  output seg_kind_e kind
);
  always_comb begin
    cmd_ready  = at_edge;
    pay_ready  = at_edge & busy & ~cmd_valid;
    xfer_ready = at_edge & ~busy & ~cmd_valid;
    kind       = SEG_FILL;
    if (cmd_valid && cmd_ready)
      kind = SEG_CMD;
    else if (pay_valid && pay_ready)
      kind = SEG_PAY;
    else if (xfer_valid && xfer_ready && len_ok)
      kind = SEG_HDR;
  end
endmodule

// File: rtl/plt_xfer_cnt.sv
// Counts the payload words still owed by the transfer in flight.
module plt_xfer_cnt #(
  parameter int WORD_B    = 4,
  parameter int MAX_PAY_B = 64,
  parameter int LEN_W     = 7,
  parameter int WCNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_fire,
  input  logic             pay_fire,
  output logic             len_ok,
  output logic             busy,
  output logic             len_err
);
  logic [WCNT_W-1:0] words_q;
  logic              err_q;

  assign len_ok = (xfer_len >= LEN_W'(WORD_B)) &&
                  (xfer_len <= LEN_W'(MAX_PAY_B)) &&
                  ((xfer_len % LEN_W'(WORD_B)) == '0);
  assign busy    = |words_q;
  assign len_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= xfer_fire & ~len_ok;
      if (xfer_fire && len_ok)
        words_q <= WCNT_W'(xfer_len / LEN_W'(WORD_B));
      else if (pay_fire)
        words_q <= words_q - WCNT_W'(1);
    end
  end
endmodule

// File: rtl/plt_seg_reg.sv
// Segment shifter: holds the current segment and drives the lane byte.
module plt_seg_reg #(
  parameter int SEG_B = 12,
  parameter int SL_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEG_B*8-1:0] ld_bytes,
  input  logic [SL_W-1:0]    ld_len,
  input  logic               ld_ctl,
  output logic               at_edge,
  output logic [7:0]         lane_data,
  output logic               lane_ctl
);
  logic [SEG_B*8-1:0] sh_q;
  logic [SEG_B*8-1:0] sh_nxt;
  logic [SL_W-1:0]    left_q;
  logic               ctl_q;

  assign at_edge = (left_q == SL_W'(1));

  for (genvar i = 0; i < SEG_B; i++) begin : g_byte
    if (i == SEG_B - 1) begin : g_top
      assign sh_nxt[i*8 +: 8] = at_edge ? ld_bytes[i*8 +: 8] : 8'h00;
    end else begin : g_low
      assign sh_nxt[i*8 +: 8] = at_edge ? ld_bytes[i*8 +: 8] : sh_q[(i+1)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= SL_W'(1);
      ctl_q  <= 1'b1;
    end else begin
      sh_q <= sh_nxt;
      if (at_edge) begin
        left_q <= ld_len;
        ctl_q  <= ld_ctl;
      end else begin
        left_q <= left_q - SL_W'(1);
      end
    end
  end

  assign lane_data = sh_q[7:0];
  assign lane_ctl  = ctl_q;
endmodule

// File: rtl/prio_link_tx.sv
module prio_link_tx
  import plt_pkg::*;
#(
  parameter int HDR_B       = 12,
  parameter int HDR_SHORT_B = 8,
  parameter int CMD_B       = 8,
  parameter int CMD_SHORT_B = 4,
  parameter int WORD_B      = 4,
  parameter int MAX_PAY_B   = 64,
  localparam int SEG_B      = max3(HDR_B, CMD_B, WORD_B),
  localparam int SL_W       = $clog2(SEG_B + 1),
  localparam int LEN_W      = $clog2(MAX_PAY_B + 1),
  localparam int WCNT_W     = $clog2(MAX_PAY_B / WORD_B + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_long,
  input  logic [CMD_B*8-1:0]    cmd_data,
  input  logic                  xfer_valid,
  output logic                  xfer_ready,
  input  logic                  xfer_hdr_long,
  input  logic [LEN_W-1:0]      xfer_len,
  input  logic [HDR_B*8-1:0]    xfer_hdr,
  input  logic                  pay_valid,
  output logic                  pay_ready,
  input  logic [WORD_B*8-1:0]   pay_data,
  output logic [BYTE_W-1:0]     lane_data,
  output logic                  lane_ctl,
  output logic                  len_err
);
  seg_kind_e          kind;
  logic               at_edge;
  logic               busy;
  logic               len_ok;
  logic [SEG_B*8-1:0] seg_bytes;
  logic [SL_W-1:0]    seg_len;
  logic               seg_ctl;

  plt_pick u_pick (
    .at_edge    (at_edge),
    .cmd_valid  (cmd_valid),
    .xfer_valid (xfer_valid),
    .len_ok     (len_ok),
    .busy       (busy),
    .pay_valid  (pay_valid),
    .cmd_ready  (cmd_ready),
    .xfer_ready (xfer_ready),
    .pay_ready  (pay_ready),
    .kind       (kind)
  );

  plt_xfer_cnt #(
    .WORD_B    (WORD_B),
    .MAX_PAY_B (MAX_PAY_B),
    .LEN_W     (LEN_W),
    .WCNT_W    (WCNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .xfer_len  (xfer_len),
    .xfer_fire (xfer_valid & xfer_ready),
    .pay_fire  (pay_valid & pay_ready),
    .len_ok    (len_ok),
    .busy      (busy),
    .len_err   (len_err)
  );

  always_comb begin
    seg_bytes = '0;
    seg_len   = SL_W'(1);
    seg_ctl   = 1'b1;
    unique case (kind)
      SEG_CMD: begin
        seg_bytes[CMD_B*8-1:0] = cmd_data;
        seg_len = cmd_long ? SL_W'(CMD_B) : SL_W'(CMD_SHORT_B);
      end
      SEG_HDR: begin
        seg_bytes[HDR_B*8-1:0] = xfer_hdr;
        seg_len = xfer_hdr_long ? SL_W'(HDR_B) : SL_W'(HDR_SHORT_B);
      end
      SEG_PAY: begin
        seg_bytes[WORD_B*8-1:0] = pay_data;
        seg_len = SL_W'(WORD_B);
        seg_ctl = 1'b0;
      end
      default: ;
    endcase
  end

  plt_seg_reg #(
    .SEG_B (SEG_B),
    .SL_W  (SL_W)
  ) u_seg (
    .clk       (clk),
    .rst       (rst),
    .ld_bytes  (seg_bytes),
    .ld_len    (seg_len),
    .ld_ctl    (seg_ctl),
    .at_edge   (at_edge),
    .lane_data (lane_data),
    .lane_ctl  (lane_ctl)
  );
endmodule

// File: rtl/plt_tx_chk.sv
module plt_tx_chk #(
  parameter int WORD_B    = 4,
  parameter int MAX_PAY_B = 64,
  parameter int LEN_W     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [7:0]       cmd_b0,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [LEN_W-1:0] xfer_len,
  input logic [7:0]       hdr_b0,
  input logic             pay_valid,
  input logic             pay_ready,
  input logic [7:0]       pay_b0,
  input logic [7:0]       lane_data,
  input logic             lane_ctl,
  input logic             len_err
);
  logic bad_len;
  assign bad_len = (xfer_len < LEN_W'(WORD_B)) || (xfer_len > LEN_W'(MAX_PAY_B)) ||
                   ((xfer_len % LEN_W'(WORD_B)) != '0);

  AST_RST_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (lane_data == 8'h00 && lane_ctl && !len_err)); // R1
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready && !bad_len) |=> (lane_ctl && lane_data == $past(hdr_b0))); // R3
  AST_PAY_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && pay_ready) |=> (!lane_ctl && lane_data == $past(pay_b0))); // R4
  AST_CMD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (lane_ctl && lane_data == $past(cmd_b0))); // R5
  AST_CMD_PRECEDES: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (!pay_ready && !xfer_ready)); // R6
  AST_CMD_WHOLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R8
  AST_BAD_LEN: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready && bad_len) |=> (len_err && lane_ctl && lane_data == 8'h00)); // R9
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(xfer_ready && pay_ready)); // R12
endmodule

bind prio_link_tx plt_tx_chk #(
  .WORD_B    (WORD_B),
  .MAX_PAY_B (MAX_PAY_B),
  .LEN_W     (LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_b0     (cmd_data[7:0]),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_len   (xfer_len),
  .hdr_b0     (xfer_hdr[7:0]),
  .pay_valid  (pay_valid),
  .pay_ready  (pay_ready),
  .pay_b0     (pay_data[7:0]),
  .lane_data  (lane_data),
  .lane_ctl   (lane_ctl),
  .len_err    (len_err)
);

// File: tb/tb_prio_link_tx.sv
module tb_prio_link_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_long = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        xfer_valid = 1'b0, xfer_hdr_long = 1'b0;
  logic [6:0]  xfer_len = '0;
  logic [95:0] xfer_hdr = '0;
  logic        pay_en = 1'b0;
  logic [31:0] pay_data;
  logic        cmd_ready, xfer_ready, pay_ready;
  logic [7:0]  lane_data;
  logic        lane_ctl, len_err;

  int total = 0, bad = 0;
  int pw = 0, pw_base = 0, cur_tag = 0;
  bit cap_en = 1'b0;
  int n_cap = 0, n_exp = 0;
  logic [7:0] cap_b [128];
  logic       cap_c [128];
  logic [7:0] exp_b [128];
  logic       exp_c [128];

  always #10 clk = ~clk;

  prio_link_tx dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_long(cmd_long), .cmd_data(cmd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_hdr_long(xfer_hdr_long),
    .xfer_len(xfer_len), .xfer_hdr(xfer_hdr),
    .pay_valid(pay_en), .pay_ready(pay_ready), .pay_data(pay_data),
    .lane_data(lane_data), .lane_ctl(lane_ctl), .len_err(len_err)
  );

  function automatic logic [7:0] hdr_byte(int tag, int i);
    return 8'(8'h80 + tag * 12 + i);
  endfunction
  function automatic logic [7:0] pay_byte(int tag, int idx);
    return 8'(idx + 1 + tag * 4);
  endfunction
  function automatic logic [7:0] cmd_byte(int tag, int i);
    return 8'(8'hC0 + tag * 8 + i);
  endfunction

  assign pay_data = {pay_byte(cur_tag, (pw - pw_base) * 4 + 3), pay_byte(cur_tag, (pw - pw_base) * 4 + 2),
                     pay_byte(cur_tag, (pw - pw_base) * 4 + 1), pay_byte(cur_tag, (pw - pw_base) * 4)};

  always @(posedge clk) if (pay_en && pay_ready) pw <= pw + 1;

  always @(negedge clk)
    if (cap_en && !(lane_ctl && lane_data == 8'h00) && n_cap < 128) begin
      cap_b[n_cap] = lane_data;
      cap_c[n_cap] = lane_ctl;
      n_cap++;
    end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic [7:0] b, logic c);
    exp_b[n_exp] = b; exp_c[n_exp] = c; n_exp++;
  endtask
  task automatic push_hdr(bit hl, int tag);
    for (int i = 0; i < (hl ? 12 : 8); i++) push(hdr_byte(tag, i), 1'b1);
  endtask
  task automatic push_cmd(bit lg, int tag);
    for (int i = 0; i < (lg ? 8 : 4); i++) push(cmd_byte(tag, i), 1'b1);
  endtask
  task automatic push_pay(int tag, int w0, int w1);
    for (int w = w0; w < w1; w++)
      for (int b = 0; b < 4; b++) push(pay_byte(tag, w * 4 + b), 1'b0);
  endtask

  task automatic cmp_seq(string req);
    int first;
    first = -1;
    for (int i = 0; i < n_exp && i < n_cap; i++)
      if (first < 0 && (cap_b[i] !== exp_b[i] || cap_c[i] !== exp_c[i])) first = i;
    if (n_cap != n_exp) chk(1'b0, req, "byte count", n_cap, n_exp);
    else if (first >= 0)
      chk(1'b0, req, $sformatf("byte %0d data/flag", first),
          {cap_c[first], cap_b[first]}, {exp_c[first], exp_b[first]});
    else chk(1'b1, req, "sequence", n_cap, n_exp);
  endtask

  task automatic start_cap(int tag);
    n_cap = 0; n_exp = 0; cur_tag = tag; pw_base = pw; cap_en = 1'b1;
  endtask

  task automatic send_xfer(bit hl, int len, int tag);
    xfer_valid = 1'b1; xfer_hdr_long = hl; xfer_len = 7'(len);
    for (int i = 0; i < 12; i++) xfer_hdr[i*8 +: 8] = hdr_byte(tag, i);
    while (!xfer_ready) @(negedge clk);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic send_cmd(bit lg, int tag);
    cmd_valid = 1'b1; cmd_long = lg;
    for (int i = 0; i < 8; i++) cmd_data[i*8 +: 8] = cmd_byte(tag, i);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // fields: [15] long header, [14] long command, [13:7] payload bytes,
  // [6:3] payload words sent before the command is raised (15 = no command)
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 7'd4,  4'd15, 3'd0},
    {1'b1, 1'b0, 7'd8,  4'd15, 3'd0},
    {1'b0, 1'b1, 7'd16, 4'd1,  3'd0},
    {1'b1, 1'b1, 7'd64, 4'd8,  3'd0},
    {1'b0, 1'b0, 7'd12, 4'd0,  3'd0},
    {1'b0, 1'b1, 7'd8,  4'd2,  3'd0}
  };

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(lane_data == 8'h00 && lane_ctl == 1'b1 && len_err == 1'b0, "R1", "lane after reset",
        {lane_ctl, lane_data}, 256);
    chk(xfer_ready && cmd_ready && !pay_ready, "R1", "readies after reset",
        {xfer_ready, cmd_ready, pay_ready}, 6);

    // R2: idle lane carries only filler
    start_cap(0);
    repeat (10) @(negedge clk);
    cap_en = 1'b0;
    chk(n_cap == 0, "R2", "non-filler bytes while idle", n_cap, 0);

    // table walk: R3 R4 R5 R6 R7
    pay_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      automatic bit hl = VEC[v][15];
      automatic bit cl = VEC[v][14];
      automatic int len = int'(VEC[v][13:7]);
      automatic int k = int'(VEC[v][6:3]);
      automatic int words = len / 4;
      start_cap(v);
      send_xfer(hl, len, v);
      if (k != 15) begin
        while (pw - pw_base < k) @(negedge clk);
        send_cmd(cl, v);
      end
      while (pw - pw_base < words) @(negedge clk);
      repeat (20) @(negedge clk);
      cap_en = 1'b0;
      push_hdr(hl, v);
      if (k == 15) push_pay(v, 0, words);
      else begin
        push_pay(v, 0, k);
        push_cmd(cl, v);
        push_pay(v, k, words);
      end
      case (v)
        0, 1:    cmp_seq("R3/R4");
        4:       cmp_seq("R7");
        default: cmp_seq("R6/R5");
      endcase
    end

    // R9: bad lengths consumed with a one-cycle flag and nothing sent
    start_cap(0);
    send_xfer(1'b0, 6, 0);
    chk(len_err == 1'b1, "R9", "flag after len 6", len_err, 1);
    @(negedge clk);
    chk(len_err == 1'b0, "R9", "flag one cycle only", len_err, 0);
    send_xfer(1'b0, 68, 0);
    chk(len_err == 1'b1, "R9", "flag after len 68", len_err, 1);
    send_xfer(1'b1, 0, 0);
    chk(len_err == 1'b1, "R9", "flag after len 0", len_err, 1);
    repeat (16) @(negedge clk);
    cap_en = 1'b0;
    chk(n_cap == 0 && xfer_ready, "R9", "bytes sent for rejected", n_cap, 0);

    // R8: back-to-back commands, second waits for the whole first one
    start_cap(0);
    send_cmd(1'b1, 6);
    chk(cmd_ready == 1'b0, "R8", "ready during command", cmd_ready, 0);
    send_cmd(1'b0, 7);
    repeat (12) @(negedge clk);
    cap_en = 1'b0;
    push_cmd(1'b1, 6);
    push_cmd(1'b0, 7);
    cmp_seq("R8");

    // R10: payload stall fills with filler, then payload resumes
    pay_en = 1'b0;
    start_cap(6);
    send_xfer(1'b0, 8, 6);
    repeat (20) @(negedge clk);
    chk(n_cap == 8 && lane_ctl && lane_data == 8'h00, "R10", "bytes before payload offered", n_cap, 8);
    pay_en = 1'b1;
    while (pw - pw_base < 2) @(negedge clk);
    repeat (12) @(negedge clk);
    cap_en = 1'b0;
    push_hdr(1'b0, 6);
    push_pay(6, 0, 2);
    cmp_seq("R10");

    // R12 then R11: reset in the middle of a long transfer
    start_cap(7);
    send_xfer(1'b1, 64, 7);
    while (pw - pw_base < 3) @(negedge clk);
    chk(xfer_ready == 1'b0, "R12", "descriptor ready mid-payload", xfer_ready, 0);
    cap_en = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(lane_ctl && lane_data == 8'h00 && xfer_ready && !pay_ready, "R11", "state after reset",
        {xfer_ready, pay_ready, lane_ctl}, 5);
    begin
      automatic int pw_now = pw;
      repeat (10) @(negedge clk);
      chk(pw == pw_now, "R11", "payload words taken after reset", pw - pw_now, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule